// File: doc/BRIEF.md
# Serial NOR Flash Target

This block models the device side of a serial NOR flash memory in synthesizable logic. It sits on a four-wire serial bus as a target, with clock, data-in, data-out and an active-low select. It runs its own system clock, and that clock is much faster than the serial clock. All three bus inputs are synchronized into that domain, and bus edges are recovered from the synchronized levels. The array holds 8 KB by default. Any address bits above the array size are dropped, so the address space aliases.

Each transfer starts on the falling edge of select and ends on its rising edge. The first byte is a command, and only single-lane commands are decoded. The block supports plain and fast reads, write enable, page program, 4 KB sector erase and status read. Program and erase follow flash semantics: program can only clear bits, and erase returns a whole sector to 0xFF. Both need the write-enable latch to be set first, and both run in a timed busy window that begins when select rises. After reset, the block spends a busy window filling the whole array with 0xFF.

Top module: `spi_nor_target`

## Requirements
- R1: After reset the status byte reads 0x01 while the array is being filled. Once busy clears, every byte reads 0xFF.
- R2: Only bus mode 0 is supported. Data-in is sampled on the rising serial clock edge, and data-out changes on the falling edge, most significant bit first. Data-out is 0 while select is high and during bytes that carry no data.
- R3: Command 0x03 takes a 3-byte big-endian address and then returns consecutive bytes for as long as the clock runs. Address bits at and above the array size are ignored, so reading continues from byte 0 after the last byte.
- R4: Command 0x0B takes a 3-byte address and one dummy byte, then returns data exactly as 0x03 does.
- R5: Command 0x05 returns the status byte for every byte clocked. Bit 0 is BUSY, bit 1 is the write-enable latch, and the other bits are 0. It is also served while busy.
- R6: Command 0x06 sets the write-enable latch when select rises.
- R7: Command 0x02 takes a 3-byte address and data bytes. When select rises, each addressed byte becomes its old value ANDed with the new value. The byte offset wraps within the 256-byte page, and when a page offset is written twice the later byte wins.
- R8: Command 0x20 takes a 3-byte address. When select rises, the 4 KB sector that holds the address is set to 0xFF, and other sectors are unchanged.
- R9: Commands 0x02 and 0x20 have no effect while the write-enable latch is clear.
- R10: Program and erase set BUSY as they start and keep the latch set while running. When they finish, BUSY and the latch both clear, so the status returns 0x00.
- R11: While BUSY is set, every command except 0x05 is ignored. A read returns 0x00 and a write enable leaves the latch clear.
- R12: A command whose address is cut short by select rising is discarded. An erase cut off this way erases nothing and leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |

## Verification
The bench probes the points where a flash model usually goes wrong. A program with more than 256 bytes must wrap inside its page instead of spilling into the next page. A second program must only clear bits and never set them. A read that runs past the last byte must restart at byte 0, and an address with high bits set must alias onto the low array. Several commands are sent while the device is busy: a read must return zeros and a write enable must be lost, and a design that leaked them through would return stored data or keep the latch set. An erase cut off mid-address must leave the array and the latch untouched. Program and erase are also sent with the latch clear and must change nothing.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_FREAD = 8'h0B;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_SERA  = 8'h20;
  localparam logic [7:0] OPC_RDSR  = 8'h05;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_RLOAD, ST_RDATA,
    ST_PDATA, ST_STAT, ST_WREN, ST_EARM, ST_DROP
  } cmd_st_e;

  typedef enum logic [1:0] {ENG_INIT, ENG_PROG, ENG_ERASE} eng_op_e;
endpackage

// File: rtl/spi_nor_sync.sv
module spi_nor_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_nor_shifter.sv
module spi_nor_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic       cs_act_i,
  input  logic [7:0] tx_byte_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       miso_o
);
  logic       sclk_d;
  logic       rise, fall;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  assign rise = cs_act_i & sclk_i & ~sclk_d;
  assign fall = cs_act_i & ~sclk_i & sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d     <= 1'b0;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      sclk_d     <= sclk_i;
      byte_vld_o <= 1'b0;
      if (!cs_act_i) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[5:0], mosi_i};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_vld_o <= 1'b1;
            byte_o     <= {rx_sh, mosi_i};
          end
        end
        // byte boundary: present next byte's MSB on this falling edge
        if (fall) begin
          if (bit_cnt == 3'd0) tx_sh <= tx_byte_i;
          else                 tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign miso_o = cs_act_i & tx_sh[7];

  p_miso_rise_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && $past(cs_act_i)) |-> $stable(miso_o));
endmodule

// File: rtl/spi_nor_cmd.sv
module spi_nor_cmd
  import spi_nor_pkg::*;
#(
  parameter int AW = 13,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_fall_i,
  input  logic          cs_rise_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [7:0]    tx_byte_o,
  output logic          buf_we_o,
  output logic [PW-1:0] buf_addr_o,
  output logic [7:0]    buf_data_o,
  output logic          start_prog_o,
  output logic          start_erase_o,
  output logic [AW-3:0] op_waddr_o
);
  cmd_st_e     st_q;
  logic [7:0]  op_q;
  logic [1:0]  acnt_q;
  logic [AW-1:0] addr_q;
  logic        wel_q;
  logic        pp_any_q;
  logic [7:0]  status;

  assign status     = {6'b0, wel_q, busy_i};
  assign rd_addr_o  = addr_q;
  assign op_waddr_o = addr_q[AW-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      op_q          <= '0;
      acnt_q        <= '0;
      addr_q        <= '0;
      wel_q         <= 1'b0;
      pp_any_q      <= 1'b0;
      tx_byte_o     <= '0;
      buf_we_o      <= 1'b0;
      buf_addr_o    <= '0;
      buf_data_o    <= '0;
      start_prog_o  <= 1'b0;
      start_erase_o <= 1'b0;
    end else begin
      buf_we_o      <= 1'b0;
      start_prog_o  <= 1'b0;
      start_erase_o <= 1'b0;
      if (done_i) wel_q <= 1'b0;
      if (cs_fall_i) begin
        st_q      <= ST_OPC;
        tx_byte_o <= '0;
        pp_any_q  <= 1'b0;
      end else if (cs_rise_i) begin
        case (st_q)
          ST_WREN:  wel_q         <= 1'b1;
          ST_EARM:  start_erase_o <= 1'b1;
          ST_PDATA: start_prog_o  <= pp_any_q;
          default: ;
        endcase
        st_q      <= ST_IDLE;
        tx_byte_o <= '0;
      end else if (st_q == ST_RLOAD) begin
        tx_byte_o <= rd_data_i;
        addr_q    <= addr_q + 1'b1;
        st_q      <= ST_RDATA;
      end else if (byte_vld_i) begin
        case (st_q)
          ST_OPC: begin
            acnt_q <= '0;
            op_q   <= byte_i;
            if (byte_i == OPC_RDSR) begin
              st_q      <= ST_STAT;
              tx_byte_o <= status;
            end else if (busy_i) begin
              st_q <= ST_DROP;
            end else begin
              case (byte_i)
                OPC_WREN:            st_q <= ST_WREN;
                OPC_READ, OPC_FREAD: st_q <= ST_ADDR;
                OPC_PROG, OPC_SERA:  st_q <= wel_q ? ST_ADDR : ST_DROP;
                default:             st_q <= ST_DROP;
              endcase
            end
          end
          ST_ADDR: begin
            addr_q <= {addr_q[AW-9:0], byte_i};
            acnt_q <= acnt_q + 2'd1;
            if (acnt_q == 2'd2) begin
              case (op_q)
                OPC_READ:  st_q <= ST_RLOAD;
                OPC_FREAD: st_q <= ST_DUMMY;
                OPC_PROG:  st_q <= ST_PDATA;
                default:   st_q <= ST_EARM;
              endcase
            end
          end
          ST_DUMMY: st_q <= ST_RLOAD;
          ST_RDATA: begin
            tx_byte_o <= rd_data_i;
            addr_q    <= addr_q + 1'b1;
          end
          ST_PDATA: begin
            buf_we_o           <= 1'b1;
            buf_addr_o         <= addr_q[PW-1:0];
            buf_data_o         <= byte_i;
            addr_q[PW-1:0]     <= addr_q[PW-1:0] + 1'b1;
            pp_any_q           <= 1'b1;
          end
          ST_STAT:          tx_byte_o <= status;
          ST_WREN, ST_EARM: st_q <= ST_DROP;
          default: ;
        endcase
      end
    end
  end

  p_start_needs_wel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_o || start_erase_o) |-> wel_q);
  p_done_clears_wel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !wel_q);
endmodule

// File: rtl/spi_nor_array.sv
module spi_nor_array
  import spi_nor_pkg::*;
#(
  parameter int MEM_BYTES    = 8192,
  parameter int SECTOR_BYTES = 4096,
  parameter int PAGE_BYTES   = 256,
  parameter int BUSY_CYCLES  = 1500,
  localparam int AW          = $clog2(MEM_BYTES),
  localparam int PW          = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          buf_we_i,
  input  logic [PW-1:0] buf_addr_i,
  input  logic [7:0]    buf_data_i,
  input  logic          start_prog_i,
  input  logic          start_erase_i,
  input  logic [AW-3:0] op_waddr_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam int MEM_WORDS  = MEM_BYTES / 4;
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int SEC_WORDS  = SECTOR_BYTES / 4;
  localparam int WAW        = AW - 2;
  localparam int PWW        = PW - 2;
  localparam int TW         = $clog2(BUSY_CYCLES + 1);
  localparam logic [WAW-1:0] PG_MASK  = ~WAW'(PAGE_WORDS - 1);
  localparam logic [WAW-1:0] SEC_MASK = ~WAW'(SEC_WORDS - 1);

  logic [31:0]    mem_q [MEM_WORDS];
  logic [31:0]    buf_q [PAGE_WORDS];
  eng_op_e        op_q;
  logic           sweep_q, busy_d_q;
  logic [WAW-1:0] base_q, idx_q, end_q, wr_idx;
  logic [TW-1:0]  timer_q;
  logic [31:0]    rd_word, old_word, wr_word;

  assign rd_word   = mem_q[rd_addr_i[AW-1:2]];
  assign rd_data_o = rd_word[8*rd_addr_i[1:0] +: 8];

  assign wr_idx   = base_q + idx_q;
  assign old_word = mem_q[wr_idx];
  assign wr_word  = (op_q == ENG_PROG) ? (old_word & buf_q[idx_q[PWW-1:0]]) : '1;

  assign busy_o = sweep_q | (timer_q != '0);
  assign done_o = busy_d_q & ~busy_o & (op_q != ENG_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= ENG_INIT;
      sweep_q  <= 1'b1;
      base_q   <= '0;
      idx_q    <= '0;
      end_q    <= WAW'(MEM_WORDS - 1);
      timer_q  <= '0;
      busy_d_q <= 1'b1;
    end else begin
      busy_d_q <= busy_o;
      if (timer_q != '0) timer_q <= timer_q - 1'b1;
      if (start_prog_i || start_erase_i) begin
        op_q    <= start_prog_i ? ENG_PROG : ENG_ERASE;
        base_q  <= op_waddr_i & (start_prog_i ? PG_MASK : SEC_MASK);
        end_q   <= start_prog_i ? WAW'(PAGE_WORDS - 1) : WAW'(SEC_WORDS - 1);
        idx_q   <= '0;
        sweep_q <= 1'b1;
        timer_q <= TW'(BUSY_CYCLES);
      end else if (sweep_q) begin
        if (idx_q == end_q) sweep_q <= 1'b0;
        else                idx_q   <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (sweep_q) mem_q[wr_idx] <= wr_word;
  end

  // commit also restores the buffer word to all ones (AND identity)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_WORDS; i++) buf_q[i] <= '1;
    end else if (sweep_q && op_q == ENG_PROG) begin
      buf_q[idx_q[PWW-1:0]] <= '1;
    end else if (buf_we_i) begin
      buf_q[buf_addr_i[PW-1:2]][8*buf_addr_i[1:0] +: 8] <= buf_data_i;
    end
  end

  p_no_buf_write_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !buf_we_i);
  p_start_only_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_i || start_erase_i) |-> !busy_o);
  p_busy_after_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_i || start_erase_i) |=> busy_o);
  p_prog_clears_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_q && op_q == ENG_PROG && !start_prog_i && !start_erase_i)
      |=> ((mem_q[$past(wr_idx)] & ~$past(old_word)) == '0));
endmodule

// File: rtl/spi_nor_target.sv
module spi_nor_target #(
  parameter int MEM_BYTES    = 8192,
  parameter int SECTOR_BYTES = 4096,
  parameter int PAGE_BYTES   = 256,
  parameter int BUSY_CYCLES  = 1500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [2:0]    pins_s;
  logic          cs_act, cs_act_d, cs_fall, cs_rise;
  logic          byte_vld, buf_we, start_prog, start_erase, busy, done;
  logic [7:0]    byte_rx, tx_byte, rd_data, buf_data;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] buf_addr;
  logic [AW-3:0] op_waddr;

  spi_nor_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({csn_i, mosi_i, sclk_i}), .q_o(pins_s)
  );

  assign cs_act = ~pins_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_act_d <= 1'b0;
    else         cs_act_d <= cs_act;
  end

  assign cs_fall = cs_act & ~cs_act_d;
  assign cs_rise = ~cs_act & cs_act_d;

  spi_nor_shifter u_shift (
    .clk_i, .rst_ni, .sclk_i(pins_s[0]), .mosi_i(pins_s[1]), .cs_act_i(cs_act),
    .tx_byte_i(tx_byte), .byte_vld_o(byte_vld), .byte_o(byte_rx), .miso_o
  );

  spi_nor_cmd #(.AW(AW), .PW(PW)) u_cmd (
    .clk_i, .rst_ni, .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .byte_vld_i(byte_vld), .byte_i(byte_rx), .busy_i(busy), .done_i(done),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .tx_byte_o(tx_byte),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_data_o(buf_data),
    .start_prog_o(start_prog), .start_erase_o(start_erase), .op_waddr_o(op_waddr)
  );

  spi_nor_array #(
    .MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_array (
    .clk_i, .rst_ni, .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .buf_we_i(buf_we), .buf_addr_i(buf_addr), .buf_data_i(buf_data),
    .start_prog_i(start_prog), .start_erase_i(start_erase),
    .op_waddr_i(op_waddr), .busy_o(busy), .done_o(done)
  );
endmodule

// File: tb/spi_nor_target_tb.sv
module spi_nor_target_tb;
  localparam int HALF  = 6;
  localparam int MEMSZ = 8192;
  localparam int WAITC = 1700;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  int   nchk = 0, nfail = 0, idle_err = 0, hi_cnt = 0;
  logic ref_wel = 1'b0;
  logic [7:0] ref_mem [int];

  always #4 clk = ~clk;

  spi_nor_target u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi), .miso_o(miso)
  );

  // R2: data-out must be low once select has been high for a few clocks
  always @(negedge clk) begin
    if (csn && rst_ni) hi_cnt++; else hi_cnt = 0;
    if (hi_cnt > 4 && miso !== 1'b0) idle_err++;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_rd(input int a);
    int k = a % MEMSZ;
    return ref_mem.exists(k) ? ref_mem[k] : 8'hFF;
  endfunction

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_cmd(input logic [7:0] q[$], input int nrd, output logic [7:0] rx[$]);
    logic [7:0] r;
    rx = {};
    @(negedge clk);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    foreach (q[i]) spi_byte(q[i], r);
    for (int i = 0; i < nrd; i++) begin
      spi_byte(8'h00, r);
      rx.push_back(r);
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic stat_chk(input logic [7:0] exp, input string req);
    logic [7:0] rx[$];
    spi_cmd('{8'h05}, 2, rx);
    chk(req, rx[0], exp);
    chk(req, rx[1], exp);
  endtask

  task automatic read_chk(input logic [7:0] opc, input int addr, input int n, input string req);
    logic [7:0] q[$];
    logic [7:0] rx[$];
    q = '{opc, 8'(addr >> 16), 8'(addr >> 8), 8'(addr)};
    if (opc == 8'h0B) q.push_back(8'h00);
    spi_cmd(q, n, rx);
    for (int i = 0; i < n; i++) chk(req, rx[i], ref_rd(addr + i));
  endtask

  task automatic wren();
    logic [7:0] rx[$];
    spi_cmd('{8'h06}, 0, rx);
    ref_wel = 1'b1;
  endtask

  task automatic prog(input int addr, input logic [7:0] d[$]);
    logic [7:0] q[$];
    logic [7:0] rx[$];
    logic [7:0] pend [int];
    int base, off;
    q = '{8'h02, 8'(addr >> 16), 8'(addr >> 8), 8'(addr)};
    foreach (d[i]) q.push_back(d[i]);
    spi_cmd(q, 0, rx);
    if (ref_wel && d.size() > 0) begin
      base = (addr % MEMSZ) & ~255;
      off  = addr & 255;
      foreach (d[i]) begin
        pend[off] = d[i];
        off = (off + 1) & 255;
      end
      foreach (pend[o]) ref_mem[base + o] = ref_rd(base + o) & pend[o];
      ref_wel = 1'b0;
    end
  endtask

  task automatic erase(input int addr);
    logic [7:0] rx[$];
    int base;
    spi_cmd('{8'h20, 8'(addr >> 16), 8'(addr >> 8), 8'(addr)}, 0, rx);
    if (ref_wel) begin
      base = (addr % MEMSZ) & ~4095;
      for (int i = 0; i < 4096; i++) ref_mem.delete(base + i);
      ref_wel = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d[$];
    logic [7:0] rx[$];
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 reset miso", {7'b0, miso}, 8'h00);
    stat_chk(8'h01, "R1 init busy");
    repeat (2300) @(negedge clk);
    stat_chk(8'h00, "R5 idle status");
    read_chk(8'h03, 32'h000100, 4, "R1 erased array");

    // R9: program without latch
    prog(32'h000010, '{8'hA5, 8'h3C});
    stat_chk(8'h00, "R9 no start");
    read_chk(8'h03, 32'h000010, 2, "R9 program ignored");

    wren();
    stat_chk(8'h02, "R6 latch set");
    prog(32'h000010, '{8'hA5, 8'h3C, 8'h0F});
    stat_chk(8'h03, "R10 busy and latch");
    spi_cmd('{8'h03, 8'h00, 8'h00, 8'h10}, 2, rx);
    chk("R11 read while busy", rx[0], 8'h00);
    chk("R11 read while busy", rx[1], 8'h00);
    spi_cmd('{8'h06}, 0, rx);
    repeat (WAITC) @(negedge clk);
    stat_chk(8'h00, "R10 R11 done and latch clear");
    read_chk(8'h03, 32'h00000E, 6, "R7 R3 program result");

    // R7: second program only clears bits
    wren();
    prog(32'h000010, '{8'hFF, 8'hF0});
    repeat (WAITC) @(negedge clk);
    read_chk(8'h03, 32'h000010, 3, "R7 and-merge");

    // R7: wrap within page
    wren();
    prog(32'h0001FE, '{8'h11, 8'h22, 8'h33, 8'h44});
    repeat (WAITC) @(negedge clk);
    read_chk(8'h03, 32'h0001FE, 2, "R7 page tail");
    read_chk(8'h03, 32'h000100, 3, "R7 page wrap head");

    // R7: more than 256 bytes, later byte wins
    d = {};
    for (int i = 0; i < 258; i++) d.push_back(8'(i) ^ 8'h5A);
    wren();
    prog(32'h000200, d);
    repeat (WAITC) @(negedge clk);
    read_chk(8'h03, 32'h000200, 4, "R7 overflow overwrite");
    read_chk(8'h03, 32'h0002FE, 3, "R7 page bound");

    read_chk(8'h0B, 32'h0001FE, 4, "R4 fast read");

    // R3: end-of-array wrap and high-bit alias
    wren();
    prog(32'h001FFF, '{8'hE7});
    repeat (WAITC) @(negedge clk);
    read_chk(8'h03, 32'h001FFE, 4, "R3 array wrap");
    read_chk(8'h03, 32'h00A010, 2, "R3 alias");

    // R9: erase without latch
    erase(32'h000000);
    read_chk(8'h03, 32'h000010, 2, "R9 erase ignored");

    // R12: erase with cut-short address
    wren();
    spi_cmd('{8'h20, 8'h00, 8'h00}, 0, rx);
    repeat (50) @(negedge clk);
    stat_chk(8'h02, "R12 latch kept");
    read_chk(8'h03, 32'h000010, 2, "R12 nothing erased");

    // R8: sector erase
    erase(32'h000123);
    stat_chk(8'h03, "R10 erase busy");
    repeat (WAITC) @(negedge clk);
    stat_chk(8'h00, "R10 erase done");
    read_chk(8'h03, 32'h000010, 3, "R8 sector cleared");
    read_chk(8'h03, 32'h0001FE, 4, "R8 sector cleared");
    read_chk(8'h03, 32'h001FFE, 2, "R8 other sector kept");

    nchk++;
    if (idle_err != 0) begin
      nfail++;
      $display("FAIL R2 idle miso act=%0d exp=0", idle_err);
    end
    finish_run();
  end
endmodule